// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a physical memory access may proceed. It holds a table of sixteen protection entries. Each entry has an 8-bit control byte and a 32-bit address word that stores a byte address divided by four. Software loads the table through a plain register port.

The access side is a valid/ready stream. A request carries a 32-bit byte address, an access kind and a privilege flag. One cycle after the request is accepted, a response comes back with the allow/deny verdict, a hit flag and the index of the entry that decided it. The response register applies back-pressure. A new request is taken only when no response is held or the held response is being consumed in that same cycle. While the consumer holds `rsp_ready` low, the response stays frozen and `req_ready` stays low.

Entries can match in three ways:
- An entry can be switched off.
- An entry can cover a top-of-range window whose lower bound is the previous entry's address word.
- An entry can cover a naturally aligned power-of-two region encoded in its address word.

The lowest-numbered matching entry decides the verdict. A lock bit freezes an entry and makes its permissions bind machine mode as well.

Top module: `pmp_checker`

## Requirements
- R1: The control byte fields are: bit 0 read permit, bit 1 write permit, bit 2 fetch permit, bits 4:3 match mode, bit 7 lock. A register read (`reg_sel`=0 control, 1 address) returns the stored value, with the control byte zero-extended.
- R2: Match mode 0 and match mode 2 never match any address.
- R3: Mode 1 (top-of-range) matches when prev <= addr[31:2] < word[i]. Here prev is the address word of entry i-1, or zero for entry 0.
- R4: Mode 3 (power-of-two) treats t trailing ones in the address word as a region of 2^(t+3) bytes. The region is aligned to its size and contains the address word with those low t+1 bits ignored.
- R5: When several entries match, the lowest-numbered one decides. `rsp_hit` is 1 and `rsp_idx` gives that entry's index.
- R6: When no entry matches, `rsp_hit` and `rsp_idx` are 0. A machine-mode access is allowed and a lower-privilege access is denied.
- R7: The access kind is coded 0 read, 1 write, 2 fetch; kind 3 has no permit bit and is never permitted. A machine-mode access that matches an unlocked entry is allowed. Any other matched access is allowed only if the permit bit for its kind is set.
- R8: While an entry's lock bit is set, writes to its control byte and its address word are ignored. Only reset clears the lock.
- R9: While entry i+1 is locked and in mode 1, writes to the address word of entry i are ignored.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both high, with `req_ready` = !rsp_valid || rsp_ready. Its response is valid after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response fields do not change.
- R11: After reset, all control bytes and address words read zero, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control byte, 1 selects address word |
| reg_idx | input | 4 | Entry index for register access |
| reg_wdata | input | 32 | Write data (control uses bits 7:0) |
| reg_rdata | output | 32 | Read data for the selected register |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_addr | input | 32 | Physical byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| req_priv_m | input | 1 | 1 for machine mode, 0 for lower privilege |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_allow | output | 1 | 1 when the access is permitted |
| rsp_hit | output | 1 | 1 when some entry matched |
| rsp_idx | output | 4 | Index of the deciding entry |

## Verification
A corrupted table entry shows up at the ports in two ways. A register read-back returns it at once. The next access whose address falls near that entry's bounds gets a wrong verdict or a wrong index one cycle after it is accepted. A faulty lock or freeze path shows on the first read-back after an ignored write. A faulty priority path shows as a wrong `rsp_idx` whenever regions overlap. The random phase therefore uses small, overlapping address windows, so most accesses land near some boundary.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_RSV   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } ent_cfg_t;

  localparam int CFG_W = $bits(ent_cfg_t);

endpackage

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int AREG_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               sel_addr,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [AREG_W-1:0]                  wdata,
  output logic [AREG_W-1:0]                  rdata,
  output ent_cfg_t [N_ENTRIES-1:0]           cfg_q,
  output logic [N_ENTRIES-1:0][AREG_W-1:0]   addr_q
);

  logic [N_ENTRIES-1:0] addr_frozen;

  // An address word is frozen by its own lock or by a locked TOR neighbour above.
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_freeze
    if (i < N_ENTRIES - 1) begin : g_chain
      assign addr_frozen[i] = cfg_q[i].lock |
                              (cfg_q[i+1].lock && (cfg_q[i+1].mode == MODE_TOR));
    end else begin : g_last
      assign addr_frozen[i] = cfg_q[i].lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      if (!sel_addr) begin
        if (!cfg_q[idx].lock) cfg_q[idx] <= ent_cfg_t'(wdata[CFG_W-1:0]);
      end else begin
        if (!addr_frozen[idx]) addr_q[idx] <= wdata;
      end
    end
  end

  always_comb begin
    if (sel_addr) rdata = addr_q[idx];
    else          rdata = {{(AREG_W-CFG_W){1'b0}}, cfg_q[idx]};
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int AREG_W = 32
) (
  input  match_mode_e        mode,
  input  logic [AREG_W-1:0]  this_word,
  input  logic [AREG_W-1:0]  prev_word,
  input  logic [AREG_W-1:0]  acc_word,
  output logic               hit
);

  logic [AREG_W-1:0] ignore_bits;
  logic              tor_hit;
  logic              napot_hit;

  // Trailing ones plus the first zero above them are don't-care bits.
  assign ignore_bits = this_word ^ (this_word + 1'b1);
  assign napot_hit   = ((acc_word ^ this_word) & ~ignore_bits) == '0;
  assign tor_hit     = (acc_word >= prev_word) && (acc_word < this_word);

  always_comb begin
    unique case (mode)
      MODE_TOR:   hit = tor_hit;
      MODE_NAPOT: hit = napot_hit;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel
  import pmp_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]     hits,
  input  ent_cfg_t [N_ENTRIES-1:0] cfgs,
  input  acc_kind_e                kind,
  input  logic                     priv_m,
  output logic                     allow,
  output logic                     any_hit,
  output logic [IDX_W-1:0]         win_idx
);

  ent_cfg_t win_cfg;
  logic     permit;

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    win_cfg = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
        win_cfg = cfgs[i];
      end
    end
  end

  always_comb begin
    unique case (kind)
      KIND_READ:  permit = win_cfg.r;
      KIND_WRITE: permit = win_cfg.w;
      KIND_FETCH: permit = win_cfg.x;
      default:    permit = 1'b0;
    endcase
  end

  always_comb begin
    if (!any_hit)                   allow = priv_m;
    else if (priv_m && !win_cfg.lock) allow = 1'b1;
    else                            allow = permit;
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PADDR_W   = 32,
  parameter int AREG_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [AREG_W-1:0]  reg_wdata,
  output logic [AREG_W-1:0]  reg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PADDR_W-1:0] req_addr,
  input  logic [1:0]         req_kind,
  input  logic               req_priv_m,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_allow,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_idx
);

  ent_cfg_t [N_ENTRIES-1:0]         cfg_tbl;
  logic [N_ENTRIES-1:0][AREG_W-1:0] addr_tbl;
  logic [N_ENTRIES-1:0]             hit_vec;
  logic [AREG_W-1:0]                acc_word;
  logic                             dec_allow;
  logic                             dec_hit;
  logic [IDX_W-1:0]                 dec_idx;
  logic                             take;

  pmp_regfile #(.N_ENTRIES(N_ENTRIES), .AREG_W(AREG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .sel_addr (reg_sel),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .cfg_q    (cfg_tbl),
    .addr_q   (addr_tbl)
  );

  assign acc_word = AREG_W'(req_addr >> 2);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic [AREG_W-1:0] lower;
    if (i == 0) begin : g_base
      assign lower = '0;
    end else begin : g_chain
      assign lower = addr_tbl[i-1];
    end
    pmp_entry_match #(.AREG_W(AREG_W)) u_match (
      .mode      (cfg_tbl[i].mode),
      .this_word (addr_tbl[i]),
      .prev_word (lower),
      .acc_word  (acc_word),
      .hit       (hit_vec[i])
    );
  end

  pmp_prio_sel #(.N_ENTRIES(N_ENTRIES)) u_sel (
    .hits    (hit_vec),
    .cfgs    (cfg_tbl),
    .kind    (acc_kind_e'(req_kind)),
    .priv_m  (req_priv_m),
    .allow   (dec_allow),
    .any_hit (dec_hit),
    .win_idx (dec_idx)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_allow <= dec_allow;
      rsp_hit   <= dec_hit;
      rsp_idx   <= dec_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int AREG_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_ready,
  input logic                             req_priv_m,
  input logic                             rsp_valid,
  input logic                             rsp_ready,
  input logic                             rsp_allow,
  input logic                             rsp_hit,
  input logic [IDX_W-1:0]                 rsp_idx,
  input ent_cfg_t [N_ENTRIES-1:0]         cfg_tbl,
  input logic [N_ENTRIES-1:0][AREG_W-1:0] addr_tbl
);

  AST_TAKE_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow) && $stable(rsp_hit) && $stable(rsp_idx))); // R10

  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0)); // R6

  AST_MISS_PRIV_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && !rsp_hit) |-> (rsp_allow == $past(req_priv_m))); // R6

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_lock
    AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tbl[i].lock |=> $stable(cfg_tbl[i])); // R8
    AST_LOCKED_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tbl[i].lock |=> $stable(addr_tbl[i])); // R8
    if (i > 0) begin : g_tor
      AST_TOR_PREV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tbl[i].lock && cfg_tbl[i].mode == MODE_TOR) |=> $stable(addr_tbl[i-1])); // R9
    end
  end

endmodule

bind pmp_checker pmp_checker_sva #(.N_ENTRIES(N_ENTRIES), .AREG_W(AREG_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_priv_m (req_priv_m),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_allow  (rsp_allow),
  .rsp_hit    (rsp_hit),
  .rsp_idx    (rsp_idx),
  .cfg_tbl    (cfg_tbl),
  .addr_tbl   (addr_tbl)
);

// File: tb/test_pmp_checker.sv
module test_pmp_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv_m = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;
  logic        rsp_hit;
  logic [3:0]  rsp_idx;

  int total = 0;
  int bad = 0;

  logic [7:0]  m_cfg  [16];
  logic [31:0] m_addr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_checker i_pmp_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .req_priv_m(req_priv_m), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input bit sel, input int idx, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_idx = 4'(idx); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    if (!sel) begin
      if (!m_cfg[idx][7]) m_cfg[idx] = data[7:0];
    end else begin
      if (!(m_cfg[idx][7] || (idx < 15 && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1)))
        m_addr[idx] = data;
    end
  endtask

  task automatic reg_check(input bit sel, input int idx, input string req);
    logic [31:0] exp;
    reg_sel = sel; reg_idx = 4'(idx);
    #1;
    exp = sel ? m_addr[idx] : {24'b0, m_cfg[idx]};
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic bit in_entry(input int i, input logic [31:0] w);
    logic [63:0] lo, hi, sz, base;
    int t;
    case (m_cfg[i][4:3])
      2'd1: begin
        lo = (i == 0) ? 64'd0 : {32'b0, m_addr[i-1]};
        hi = {32'b0, m_addr[i]};
        return ({32'b0, w} >= lo) && ({32'b0, w} < hi);
      end
      2'd3: begin
        t = 0;
        while (t < 32 && m_addr[i][t]) t++;
        sz = 64'd1 << (t + 1);
        base = {32'b0, m_addr[i]} & ~(sz - 1);
        return (({32'b0, w} & ~(sz - 1)) == base);
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic void model(input logic [31:0] a, input logic [1:0] k, input bit pm,
                                output bit allow, output bit hit, output logic [3:0] idx);
    logic [31:0] w;
    w = {2'b00, a[31:2]};
    hit = 0; idx = 0; allow = pm;
    for (int i = 0; i < 16; i++) begin
      if (!hit && in_entry(i, w)) begin
        hit = 1; idx = 4'(i);
        if (pm && !m_cfg[i][7]) allow = 1;
        else allow = (k == 2'd3) ? 1'b0 : m_cfg[i][k];
      end
    end
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] k, input bit pm, input string req);
    bit ea, eh; logic [3:0] ei;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv_m = pm; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model(a, k, pm, ea, eh, ei);
    check(rsp_valid == 1'b1 && rsp_allow == ea && rsp_hit == eh && rsp_idx == ei, req,
          {23'b0, rsp_valid, 2'b0, rsp_allow, rsp_hit, rsp_idx},
          {23'b0, 1'b1, 2'b0, ea, eh, ei});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ea, eh; logic [3:0] ei;
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R11 reset state
    #1;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 handshake idle", {30'b0, rsp_valid, req_ready}, 32'd1);
    for (int i = 0; i < 16; i++) begin reg_check(0, i, "R11 cfg zero"); reg_check(1, i, "R11 addr zero"); end

    // R6 empty table
    access(32'h100, 2'd0, 1'b1, "R6 miss machine");
    access(32'h100, 2'd0, 1'b0, "R6 miss user");

    // R3 top-of-range, entry 0 from zero
    reg_write(1, 0, 32'h40);
    reg_write(0, 0, 32'h09);            // TOR, read
    reg_check(0, 0, "R1 cfg readback");
    access(32'h0, 2'd0, 1'b0, "R3 tor0 low edge");
    access(32'hFC, 2'd0, 1'b0, "R3 tor0 top-1");
    access(32'h100, 2'd0, 1'b0, "R3 tor0 top excluded");
    access(32'hFC, 2'd1, 1'b0, "R7 user write no permit");
    access(32'hFC, 2'd3, 1'b0, "R7 kind3 never");
    reg_write(1, 1, 32'h80);
    reg_write(0, 1, 32'h0A);            // TOR, write
    access(32'h100, 2'd1, 1'b0, "R3 tor1 lower bound");
    access(32'h1FC, 2'd1, 1'b0, "R3 tor1 top-1");
    access(32'h200, 2'd1, 1'b0, "R3 tor1 top excluded");

    // R4 8-byte and larger power-of-two
    reg_write(1, 2, 32'h100);
    reg_write(0, 2, 32'h1C);            // NAPOT, fetch
    access(32'h404, 2'd2, 1'b0, "R4 napot8 inside");
    access(32'h408, 2'd2, 1'b0, "R4 napot8 outside");
    access(32'h3FC, 2'd2, 1'b0, "R4 napot8 below");
    reg_write(1, 3, 32'h1FF);           // 4 KiB at 0
    reg_write(0, 3, 32'h1F);            // NAPOT, rwx
    access(32'h80, 2'd1, 1'b0, "R5 priority entry0 over entry3");
    access(32'h404, 2'd2, 1'b0, "R5 priority entry2 over entry3");
    access(32'hFFC, 2'd1, 1'b0, "R4 napot4k top");
    access(32'h1000, 2'd1, 1'b0, "R4 napot4k outside");

    // R2 mode 2 never matches
    reg_write(1, 4, 32'h800);
    reg_write(0, 4, 32'h17);            // mode 2, rwx
    access(32'h2000, 2'd0, 1'b0, "R2 mode2 no match");

    // R7 machine override and lock
    access(32'h10, 2'd1, 1'b1, "R7 machine unlocked override");
    reg_write(0, 0, 32'h89);            // lock TOR read
    access(32'h10, 2'd1, 1'b1, "R7 machine locked denied");
    access(32'h10, 2'd0, 1'b1, "R7 machine locked read");

    // R8 lock freezes
    reg_write(0, 0, 32'h00);
    reg_check(0, 0, "R8 locked cfg ignores write");
    reg_write(1, 0, 32'h1234);
    reg_check(1, 0, "R8 locked addr ignores write");
    access(32'h100, 2'd0, 1'b0, "R8 region unchanged");

    // R9 locked TOR freezes previous address
    reg_write(1, 5, 32'h500);
    reg_write(1, 6, 32'h600);
    reg_write(0, 6, 32'h89);
    reg_write(1, 5, 32'h555);
    reg_check(1, 5, "R9 prev addr frozen");
    reg_write(1, 8, 32'h700);
    reg_write(1, 9, 32'h7FF);
    reg_write(0, 9, 32'h99);            // locked NAPOT
    reg_write(1, 8, 32'h777);
    reg_check(1, 8, "R9 napot lock leaves prev writable");

    // R10 back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h10; req_kind = 2'd1; req_priv_m = 1'b0; rsp_ready = 1'b0;
    @(negedge clk);
    model(32'h10, 2'd1, 1'b0, ea, eh, ei);
    check(rsp_valid && !req_ready, "R10 stall ready low", {30'b0, rsp_valid, req_ready}, 32'd2);
    req_addr = 32'h404; req_kind = 2'd2;
    @(negedge clk);
    check(rsp_valid && rsp_allow == ea && rsp_idx == ei, "R10 held response",
          {27'b0, rsp_allow, rsp_idx}, {27'b0, ea, ei});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model(32'h404, 2'd2, 1'b0, ea, eh, ei);
    check(rsp_valid && rsp_allow == ea && rsp_idx == ei, "R10 second after release",
          {27'b0, rsp_allow, rsp_idx}, {27'b0, ea, ei});

    // Random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      for (int i = 0; i < 16; i++) begin
        logic [7:0] c;
        c = 8'($urandom);
        if (ph < 2 || ($urandom % 4) != 0) c[7] = 1'b0;
        reg_write(1, i, $urandom % 300);
        reg_write(0, i, {24'b0, c});
      end
      for (int k = 0; k < 20; k++) begin
        reg_write(1'($urandom), $urandom % 16, $urandom % 300);
      end
      for (int i = 0; i < 16; i++) begin reg_check(0, i, "R1 R8 random cfg"); reg_check(1, i, "R8 R9 random addr"); end
      for (int k = 0; k < 250; k++) begin
        access($urandom % 1300, 2'($urandom), 1'($urandom), "R5 R7 random access");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule